// File: doc/BRIEF.md
# Reference-Window Clock Frequency Meter

This block measures the rate of its own fast clock against a slow reference clock of known frequency (1,193,182 Hz by default). A start pulse arms a one-shot gate window in the reference domain. The window lasts the reference frequency divided by 100 reference periods, which is 11931 periods or 10 ms at the default. The window count is loaded into a down-counter one byte at a time, low byte first. The gate stays off while the count is loaded, and counting starts only after both bytes are in.

A free-running cycle counter runs on the fast clock. It is sampled when the window opens and again when the window's terminal-count output goes active. The two events reach the fast domain through synchronizers of equal depth, so their latency cancels in the difference.

The difference is the raw count of fast cycles in the window. A sequential restoring divider divides it by 10000, which gives whole megahertz for a 10 ms window. A shift-and-add-3 sequencer then turns the quotient into decimal digits. A one-cycle done pulse marks the point where both results are updated. The results then hold until the next measurement completes.

Top module: `clock_freq_meter`

## Requirements
- R1: After reset, busy and done are 0, and cycles and mhz_bcd are all zeros.
- R2: A start pulse seen while idle sets busy in the following cycle. Busy stays 1 until the cycle in which done is 1, and is 0 in that cycle.
- R3: The window lasts exactly REF_HZ/WINDOW_DIV reference periods. This count is written into a one-shot down-counter as its low 8 bits first, then its upper bits, before counting begins.
- R4: While the reload count is being written, the counting flag and the window output are both held low. The window output goes high only when the down-counter reaches zero, and it stays high until the meter disarms the window.
- R5: cycles equals the fast-clock counter value sampled at window close minus the value sampled at window open, taken modulo 2^CYC_W. For integer clock ratios this is within 2 of (window periods × fast cycles per reference period).
- R6: mhz_bcd holds floor(cycles / DIVISOR) in BCD. Digit k occupies bits [4k+3:4k], with the least significant digit in bits [3:0]. Every digit is in the range 0 to 9.
- R7: If the quotient exceeds 10^DIGITS − 1, mhz_bcd shows all nines.
- R8: done is high for exactly one cycle per accepted start.
- R9: A start pulse while busy is ignored. It does not restart the window and does not produce an extra done.
- R10: cycles and mhz_bcd change only in a cycle in which done is 1, and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock being measured; also clocks the control and arithmetic |
| rst_n | input | 1 | Active-low asynchronous reset for both clock domains |
| ref_clk | input | 1 | Reference clock of frequency REF_HZ |
| start | input | 1 | Request a measurement (one-cycle pulse, clk domain) |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | One-cycle pulse when the results have been updated |
| cycles | output | CYC_W | Raw fast-cycle count of the last window |
| mhz_bcd | output | 4*DIGITS | Last frequency in megahertz as BCD digits |

## Verification
The assertions check these properties on every cycle:
- The loading sequence in the reference domain keeps the gate and the window output off, and the full reload value is present when counting starts.
- The window output rises only from a count of one.
- The divider remainder stays below the divisor, and every BCD digit stays decimal.
- Done is a single pulse that ends busy, and the held results change only with done.

Other behaviours depend on the ratio between the two clocks, so only the bench's scenarios can show them:
- the actual window length and cycle count at several reference periods,
- the quotient and its decimal form,
- saturation to all nines,
- a stray start during a measurement causing no extra pulse.

// File: rtl/fm_pkg.sv
package fm_pkg;

    typedef enum logic [2:0] {
        M_IDLE,
        M_ARM,
        M_WIN,
        M_DIVGO,
        M_DIV,
        M_BCD,
        M_DRAIN
    } meter_state_e;

    typedef enum logic [2:0] {
        W_IDLE,
        W_LO,
        W_HI,
        W_RUN,
        W_END
    } win_state_e;

endpackage

// File: rtl/fm_sync2.sv
module fm_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sy_t;

    sy_t sy_d, sy_q;

    always_comb begin
        sy_d    = sy_q;
        sy_d.s1 = d;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign q = sy_q.s2;

endmodule

// File: rtl/fm_ref_window.sv
module fm_ref_window
    import fm_pkg::*;
#(
    parameter int REF_HZ     = 1193182,
    parameter int WINDOW_DIV = 100,
    parameter int CNT_W      = 16
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic arm,
    output logic counting,
    output logic win_out
);

    localparam logic [CNT_W-1:0] RELOAD_V = CNT_W'(REF_HZ / WINDOW_DIV);

    typedef struct packed {
        win_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             out;
    } rw_t;

    rw_t  rw_d, rw_q;
    logic arm_s;

    fm_sync2 #(.W(1)) u_arm_sync (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .d     (arm),
        .q     (arm_s)
    );

    always_comb begin
        rw_d = rw_q;
        case (rw_q.st)
            W_IDLE: begin
                rw_d.run = 1'b0;
                rw_d.out = 1'b0;
                if (arm_s) rw_d.st = W_LO;
            end
            W_LO: begin
                rw_d.cnt[7:0] = RELOAD_V[7:0];
                rw_d.st       = W_HI;
            end
            W_HI: begin
                rw_d.cnt[CNT_W-1:8] = RELOAD_V[CNT_W-1:8];
                rw_d.run            = 1'b1;
                rw_d.st             = W_RUN;
            end
            W_RUN: begin
                rw_d.cnt = rw_q.cnt - 1'b1;
                if (rw_q.cnt == CNT_W'(1)) begin
                    rw_d.run = 1'b0;
                    rw_d.out = 1'b1;
                    rw_d.st  = W_END;
                end
            end
            W_END: begin
                if (!arm_s) begin
                    rw_d.out = 1'b0;
                    rw_d.st  = W_IDLE;
                end
            end
            default: rw_d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) rw_q <= '{st: W_IDLE, default: '0};
        else        rw_q <= rw_d;
    end

    assign counting = rw_q.run;
    assign win_out  = rw_q.out;

    // R3: both bytes in place when counting begins
    a_r3_reload_full: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (rw_q.st == W_HI) |=> (rw_q.run && rw_q.cnt == RELOAD_V));

    // R4: gate and output off while the count is loaded
    a_r4_load_gated: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (rw_q.st == W_LO || rw_q.st == W_HI) |-> (!rw_q.run && !rw_q.out));

    // R4: output rises only from a count of one
    a_r4_out_at_zero: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(rw_q.out) |-> ($past(rw_q.cnt) == CNT_W'(1) && rw_q.cnt == '0));

endmodule

// File: rtl/fm_divider.sv
module fm_divider #(
    parameter int CYC_W   = 64,
    parameter int DIVISOR = 10000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [CYC_W-1:0] dividend,
    output logic             done,
    output logic [CYC_W-1:0] quotient
);

    localparam int DIV_W  = $clog2(DIVISOR + 1);
    localparam int STEP_W = $clog2(CYC_W + 1);
    localparam logic [DIV_W:0] DVS = (DIV_W + 1)'(DIVISOR);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [CYC_W-1:0]  num;
        logic [CYC_W-1:0]  quo;
        logic [DIV_W:0]    rem;
        logic [STEP_W-1:0] step;
    } dv_t;

    dv_t dv_d, dv_q;
    logic [DIV_W:0] trial;

    always_comb begin
        dv_d      = dv_q;
        dv_d.done = 1'b0;
        trial     = {dv_q.rem[DIV_W-1:0], dv_q.num[CYC_W-1]};
        if (go && !dv_q.busy) begin
            dv_d.busy = 1'b1;
            dv_d.num  = dividend;
            dv_d.quo  = '0;
            dv_d.rem  = '0;
            dv_d.step = '0;
        end else if (dv_q.busy) begin
            dv_d.num = dv_q.num << 1;
            if (trial >= DVS) begin
                dv_d.rem = trial - DVS;
                dv_d.quo = {dv_q.quo[CYC_W-2:0], 1'b1};
            end else begin
                dv_d.rem = trial;
                dv_d.quo = {dv_q.quo[CYC_W-2:0], 1'b0};
            end
            dv_d.step = dv_q.step + 1'b1;
            if (dv_q.step == STEP_W'(CYC_W - 1)) begin
                dv_d.busy = 1'b0;
                dv_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dv_q <= '0;
        else        dv_q <= dv_d;
    end

    assign done     = dv_q.done;
    assign quotient = dv_q.quo;

    // R6: partial remainder always below the divisor
    a_r6_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
        dv_q.busy |-> (dv_q.rem < DVS));

endmodule

// File: rtl/fm_bin2bcd.sv
module fm_bin2bcd #(
    parameter int BIN_W  = 17,
    parameter int DIGITS = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go,
    input  logic [BIN_W-1:0]    value,
    output logic                done,
    output logic [4*DIGITS-1:0] bcd
);

    localparam int STEP_W = $clog2(BIN_W + 1);

    typedef struct packed {
        logic                busy;
        logic                done;
        logic [BIN_W-1:0]    bin;
        logic [4*DIGITS-1:0] dig;
        logic [STEP_W-1:0]   step;
    } bc_t;

    bc_t bc_d, bc_q;
    logic [4*DIGITS-1:0] adj;

    for (genvar k = 0; k < DIGITS; k++) begin : g_add3
        logic [3:0] nib;
        assign nib            = bc_q.dig[4*k +: 4];
        assign adj[4*k +: 4]  = (nib >= 4'd5) ? nib + 4'd3 : nib;
    end

    always_comb begin
        bc_d      = bc_q;
        bc_d.done = 1'b0;
        if (go && !bc_q.busy) begin
            bc_d.busy = 1'b1;
            bc_d.bin  = value;
            bc_d.dig  = '0;
            bc_d.step = '0;
        end else if (bc_q.busy) begin
            {bc_d.dig, bc_d.bin} = {adj, bc_q.bin} << 1;
            bc_d.step = bc_q.step + 1'b1;
            if (bc_q.step == STEP_W'(BIN_W - 1)) begin
                bc_d.busy = 1'b0;
                bc_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bc_q <= '0;
        else        bc_q <= bc_d;
    end

    assign done = bc_q.done;
    assign bcd  = bc_q.dig;

    for (genvar k = 0; k < DIGITS; k++) begin : g_chk
        // R6: each finished digit is decimal
        a_r6_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
            (!bc_q.busy) |-> (bc_q.dig[4*k +: 4] <= 4'd9));
    end

endmodule

// File: rtl/clock_freq_meter.sv
module clock_freq_meter
    import fm_pkg::*;
#(
    parameter int REF_HZ     = 1193182,
    parameter int WINDOW_DIV = 100,
    parameter int CNT_W      = 16,
    parameter int CYC_W      = 64,
    parameter int DIVISOR    = 10000,
    parameter int DIGITS     = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ref_clk,
    input  logic                start,
    output logic                busy,
    output logic                done,
    output logic [CYC_W-1:0]    cycles,
    output logic [4*DIGITS-1:0] mhz_bcd
);

    localparam int MAXV  = 10 ** DIGITS - 1;
    localparam int BIN_W = $clog2(MAXV + 1);

    typedef struct packed {
        meter_state_e        st;
        logic                arm;
        logic                busy;
        logic                done;
        logic                run_prev;
        logic                end_prev;
        logic [CYC_W-1:0]    tick;
        logic [CYC_W-1:0]    t0;
        logic [CYC_W-1:0]    delta;
        logic [CYC_W-1:0]    res_cyc;
        logic [4*DIGITS-1:0] res_bcd;
    } mt_t;

    mt_t  mt_d, mt_q;
    logic run_raw, end_raw, run_s, end_s;
    logic div_go, div_done, bcd_go, bcd_done;
    logic [CYC_W-1:0]    quo;
    logic [BIN_W-1:0]    sat;
    logic [4*DIGITS-1:0] bcd_val;

    fm_ref_window #(
        .REF_HZ     (REF_HZ),
        .WINDOW_DIV (WINDOW_DIV),
        .CNT_W      (CNT_W)
    ) u_win (
        .ref_clk  (ref_clk),
        .rst_n    (rst_n),
        .arm      (mt_q.arm),
        .counting (run_raw),
        .win_out  (end_raw)
    );

    fm_sync2 #(.W(2)) u_evt_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({run_raw, end_raw}),
        .q     ({run_s, end_s})
    );

    fm_divider #(
        .CYC_W   (CYC_W),
        .DIVISOR (DIVISOR)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go),
        .dividend (mt_q.delta),
        .done     (div_done),
        .quotient (quo)
    );

    assign sat = (quo > CYC_W'(MAXV)) ? BIN_W'(MAXV) : quo[BIN_W-1:0];

    fm_bin2bcd #(
        .BIN_W  (BIN_W),
        .DIGITS (DIGITS)
    ) u_bcd (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (bcd_go),
        .value (sat),
        .done  (bcd_done),
        .bcd   (bcd_val)
    );

    assign div_go = (mt_q.st == M_DIVGO);
    assign bcd_go = (mt_q.st == M_DIV) && div_done;

    always_comb begin
        mt_d          = mt_q;
        mt_d.done     = 1'b0;
        mt_d.tick     = mt_q.tick + 1'b1;
        mt_d.run_prev = run_s;
        mt_d.end_prev = end_s;
        case (mt_q.st)
            M_IDLE: begin
                if (start) begin
                    mt_d.arm  = 1'b1;
                    mt_d.busy = 1'b1;
                    mt_d.st   = M_ARM;
                end
            end
            M_ARM: begin
                if (run_s && !mt_q.run_prev) begin
                    mt_d.t0 = mt_q.tick;
                    mt_d.st = M_WIN;
                end
            end
            M_WIN: begin
                if (end_s && !mt_q.end_prev) begin
                    mt_d.delta = mt_q.tick - mt_q.t0;
                    mt_d.arm   = 1'b0;
                    mt_d.st    = M_DIVGO;
                end
            end
            M_DIVGO: mt_d.st = M_DIV;
            M_DIV: begin
                if (div_done) mt_d.st = M_BCD;
            end
            M_BCD: begin
                if (bcd_done) mt_d.st = M_DRAIN;
            end
            M_DRAIN: begin
                if (!run_s && !end_s) begin
                    mt_d.res_cyc = mt_q.delta;
                    mt_d.res_bcd = bcd_val;
                    mt_d.busy    = 1'b0;
                    mt_d.done    = 1'b1;
                    mt_d.st      = M_IDLE;
                end
            end
            default: mt_d.st = M_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mt_q <= '{st: M_IDLE, default: '0};
        else        mt_q <= mt_d;
    end

    assign busy    = mt_q.busy;
    assign done    = mt_q.done;
    assign cycles  = mt_q.res_cyc;
    assign mhz_bcd = mt_q.res_bcd;

    // R2: an accepted start raises busy next cycle
    a_r2_start_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R2: busy falls only with done
    a_r2_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R8: done lasts one cycle and is never seen with busy
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10: results move only with done
    a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cycles) || !$stable(mhz_bcd)) |-> done);

endmodule

// File: tb/sim_clock_freq_meter.sv
`timescale 1ns/1ps
module sim_clock_freq_meter;

    localparam int CLK_PERIOD = 10;
    localparam int REF_HZ     = 2000;
    localparam int WINDOW_DIV = 100;
    localparam int RELOAD     = REF_HZ / WINDOW_DIV;
    localparam int CYC_W      = 64;
    localparam int DIVISOR    = 3;
    localparam int DIGITS     = 3;
    localparam int MAXV       = 999;

    logic clk = 1'b0;
    logic ref_clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic busy, done;
    logic [CYC_W-1:0]    cycles;
    logic [4*DIGITS-1:0] mhz_bcd;

    int ref_half = 35;
    int total = 0;
    int bad = 0;
    int accepted = 0;
    int done_seen = 0;
    int exp_q[$];

    clock_freq_meter #(
        .REF_HZ(REF_HZ), .WINDOW_DIV(WINDOW_DIV), .CNT_W(16),
        .CYC_W(CYC_W), .DIVISOR(DIVISOR), .DIGITS(DIGITS)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .start(start),
        .busy(busy), .done(done), .cycles(cycles), .mhz_bcd(mhz_bcd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #2;
        forever #(ref_half) ref_clk = ~ref_clk;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [4*DIGITS-1:0] to_bcd(input longint v);
        logic [4*DIGITS-1:0] r = '0;
        longint x = v;
        for (int k = 0; k < DIGITS; k++) begin
            r[4*k +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

    // monitor: pops expected ratio on each done
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                int ratio;
                longint raw, q, nom;
                done_seen++;
                chk(exp_q.size() > 0, "R9 done without pending request", done_seen, accepted);
                if (exp_q.size() > 0) begin
                    ratio = exp_q.pop_front();
                    nom = longint'(RELOAD) * ratio;
                    raw = longint'(cycles);
                    chk(raw >= nom - 2 && raw <= nom + 2, "R3 R4 R5 window cycle count", raw, nom);
                    q = raw / DIVISOR;
                    if (q > MAXV) begin
                        chk(mhz_bcd == to_bcd(MAXV), "R7 saturated digits", mhz_bcd, to_bcd(MAXV));
                        q = MAXV;
                    end
                    chk(mhz_bcd == to_bcd(q), "R6 BCD megahertz", mhz_bcd, to_bcd(q));
                end
                @(negedge clk);
                chk(done == 1'b0, "R8 done one cycle", done, 0);
            end
        end
    end

    task automatic measure(input int ratio, input int stray);
        logic [CYC_W-1:0]    pc;
        logic [4*DIGITS-1:0] pb;
        ref_half = ratio * CLK_PERIOD / 2;
        repeat (4 * ratio) @(negedge clk);
        pc = cycles;
        pb = mhz_bcd;
        exp_q.push_back(ratio);
        accepted++;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", busy, 1);
        for (int s = 0; s < stray; s++) begin
            repeat (7 * ratio) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(busy == 1'b1, "R9 stray start keeps busy", busy, 1);
        end
        chk(cycles == pc && mhz_bcd == pb, "R10 results held while busy", longint'(cycles), longint'(pc));
        while (!done) @(negedge clk);
        @(negedge clk);
        chk(busy == 1'b0, "R2 busy cleared with done", busy, 0);
    endtask

    initial begin
        logic [CYC_W-1:0] hc;
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0, "R1 reset flags", {busy, done}, 0);
        chk(cycles == 0 && mhz_bcd == 0, "R1 reset results", longint'(cycles), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        measure(7, 0);
        measure(13, 3);
        measure(25, 0);
        measure(160, 0);
        measure(9, 2);
        hc = cycles;
        repeat (3000) @(negedge clk);
        chk(done_seen == accepted, "R9 one done per accepted start", done_seen, accepted);
        chk(busy == 1'b0, "R9 idle after stray starts", busy, 0);
        chk(cycles == hc, "R10 results held while idle", longint'(cycles), longint'(hc));
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", done_seen, accepted);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule